// File: doc/BRIEF.md
# Interrupt Message Delivery Engine

This block turns wire interrupts into message writes. Each interrupt pin has a routing entry supplied by a register front end. The entry gives a vector, a delivery mode, a destination index, a destination mode, a trigger mode and a mask. The engine keeps a pending bit per pin. On every free slot it picks the lowest-numbered pin that is pending, unmasked and not blocked. For that pin it presents one 32-bit address and 32-bit data word on a valid/ready message port.

Edge-triggered pins latch a rising input into their pending bit and release it once the message has gone out. Level-triggered pins mirror their input level. After each delivery they are fenced by a per-pin remote-IRR flag until an end-of-interrupt broadcast names their vector. When that broadcast arrives and the input is still high, the pin is delivered again. The remote-IRR flags are driven back to the front end so that software can read them.

Top module: `irq_delivery_engine`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `msg_valid` is 0 and every `remote_irr` bit is 0.
- R2: A level-triggered pin (`ent_trig` bit = 1) whose input has gone low is no longer pending. When an end-of-interrupt clears its remote IRR, no new message is issued.
- R3: A rising input on an edge-triggered pin (`ent_trig` bit = 0) is dropped while the pin is masked (`ent_mask` bit = 1). Unmasking the pin later does not produce a message for that edge.
- R4: When several pins are eligible, the pin with the lowest index is delivered first. The others follow in ascending order, one per handshake.
- R5: An edge-triggered pin sends exactly one message per rising edge of its input.
- R6: Delivering a level-triggered pin sets its `remote_irr` bit. While that bit is set, the pin is not delivered again, even with its input held high.
- R7: An end-of-interrupt (`eoi_valid`) with vector V clears `remote_irr` on every pin whose entry vector equals V. Such a pin that is unmasked and still asserted is delivered again. An end-of-interrupt with a different vector changes nothing.
- R8: The address is 0xFEE00000 ORed with the destination index shifted left by 12 and with the destination-mode bit at bit 2. The data word carries the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15, with all other bits zero.
- R9: When the entry's delivery mode is 3'b111 (external legacy controller), data bits 7:0 carry `extint_vector` instead of the entry vector.
- R10: While `msg_valid` is high and `msg_ready` is low, the message is held unchanged. Only one message moves per valid-and-ready cycle.
- R11: An end-of-interrupt that arrives while a message is stalled clears the matching `remote_irr` bits right away, before the next pin selection.
- R12: A pin whose entry is edge-triggered has its `remote_irr` bit cleared one cycle later.
- R13: A masked pin is never delivered. A masked level pin whose input is high is delivered once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt input pins |
| ent_vector | input | NUM_PINS x 8 | Per-pin vector from the routing entry |
| ent_dlv | input | NUM_PINS x 3 | Per-pin delivery mode |
| ent_dest | input | NUM_PINS x 16 | Per-pin destination index |
| ent_dmode | input | NUM_PINS | Per-pin destination mode bit |
| ent_trig | input | NUM_PINS | Trigger mode, 1 = level, 0 = edge |
| ent_mask | input | NUM_PINS | Mask, 1 = masked |
| extint_vector | input | 8 | Vector from the external legacy controller |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| remote_irr | output | NUM_PINS | Remote-IRR flags returned to the front end |

## Verification
Two functions can fall in the same cycle. One is the end-of-interrupt clearing of remote IRR. The other is the output port stalling with a message held. The bench holds `msg_ready` low with an edge message parked on the port, and during that stall it pulses an end-of-interrupt that matches a level pin whose input is still high. It judges the result in three ways: `remote_irr` must drop while the parked message stays intact, the level pin must not displace the parked message, and releasing `msg_ready` must produce the parked message and then the redelivery, in that order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int DEST_W = 16;

    localparam logic [31:0] MSG_ADDR_BASE = 32'hFEE0_0000;
    localparam int ADDR_DEST_LSB  = 12;
    localparam int ADDR_DMODE_BIT = 2;
    localparam int DATA_DLV_LSB   = 8;
    localparam int DATA_TRIG_BIT  = 15;

    typedef enum logic [DLV_W-1:0] {
        DLV_FIXED  = 3'b000,
        DLV_LOWPRI = 3'b001,
        DLV_SMI    = 3'b010,
        DLV_NMI    = 3'b100,
        DLV_INIT   = 3'b101,
        DLV_EXTINT = 3'b111
    } dlv_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } msg_t;

    function automatic logic [31:0] form_addr(input logic [DEST_W-1:0] dest,
                                              input logic dmode);
        logic [31:0] a;
        a = MSG_ADDR_BASE;
        a = a | (32'(dest) << ADDR_DEST_LSB);
        a[ADDR_DMODE_BIT] = a[ADDR_DMODE_BIT] | dmode;
        return a;
    endfunction

    function automatic logic [31:0] form_data(input logic [VEC_W-1:0] vec,
                                              input logic [DLV_W-1:0] dlv,
                                              input logic trig);
        logic [31:0] d;
        d = '0;
        d[VEC_W-1:0] = vec;
        d[DATA_DLV_LSB +: DLV_W] = dlv;
        d[DATA_TRIG_BIT] = trig;
        return d;
    endfunction

endpackage

// File: rtl/irq_pending_track.sv
module irq_pending_track #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] edge_sent,
    output logic [NUM_PINS-1:0] pending
);

    logic [NUM_PINS-1:0] irq_q;
    logic [NUM_PINS-1:0] pend_d;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            if (trig_level[i]) begin
                pend_d[i] = irq_in[i];
            end else begin
                pend_d[i] = (pending[i] & ~edge_sent[i])
                          | (irq_in[i] & ~irq_q[i] & ~mask[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= '0;
            pending <= '0;
        end else begin
            irq_q   <= irq_in;
            pending <= pend_d;
        end
    end

endmodule

// File: rtl/irq_rirr_track.sv
module irq_rirr_track
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            eoi_valid,
    input  logic [VEC_W-1:0]                eoi_vector,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]  ent_vector,
    input  logic [NUM_PINS-1:0]             trig_level,
    input  logic [NUM_PINS-1:0]             level_sent,
    output logic [NUM_PINS-1:0]             rirr,
    output logic [NUM_PINS-1:0]             rirr_after_eoi
);

    logic [NUM_PINS-1:0] eoi_hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_hit
        assign eoi_hit[i] = eoi_valid && (ent_vector[i] == eoi_vector);
    end

    assign rirr_after_eoi = rirr & ~eoi_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rirr <= '0;
        end else begin
            rirr <= (rirr_after_eoi | level_sent) & trig_level;
        end
    end

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int NUM_PINS = 8,
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] grant,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                any
);

    assign grant[0] = req[0];
    for (genvar i = 1; i < NUM_PINS; i++) begin : g_grant
        assign grant[i] = req[i] & ~(|req[i-1:0]);
    end

    assign any = |req;

    always_comb begin
        grant_idx = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            if (grant[k]) grant_idx = IDX_W'(k);
        end
    end

endmodule

// File: rtl/irq_delivery_engine.sv
module irq_delivery_engine
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_PINS-1:0]             irq_in,
    input  logic [NUM_PINS-1:0][7:0]        ent_vector,
    input  logic [NUM_PINS-1:0][2:0]        ent_dlv,
    input  logic [NUM_PINS-1:0][15:0]       ent_dest,
    input  logic [NUM_PINS-1:0]             ent_dmode,
    input  logic [NUM_PINS-1:0]             ent_trig,
    input  logic [NUM_PINS-1:0]             ent_mask,
    input  logic [7:0]                      extint_vector,
    input  logic                            eoi_valid,
    input  logic [7:0]                      eoi_vector,
    output logic                            msg_valid,
    input  logic                            msg_ready,
    output logic [31:0]                     msg_addr,
    output logic [31:0]                     msg_data,
    output logic [NUM_PINS-1:0]             remote_irr
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] rirr_eff;
    logic [NUM_PINS-1:0] eligible;
    logic [NUM_PINS-1:0] grant;
    logic [IDX_W-1:0]    grant_idx;
    logic                grant_any;
    logic                slot_free;
    logic                load;
    logic [NUM_PINS-1:0] sent;
    logic [NUM_PINS-1:0] edge_sent;
    logic [NUM_PINS-1:0] level_sent;
    logic [VEC_W-1:0]    sel_vec;
    msg_t                msg_d;
    msg_t                msg_q;

    irq_pending_track #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (ent_trig),
        .mask       (ent_mask),
        .edge_sent  (edge_sent),
        .pending    (pending)
    );

    irq_rirr_track #(.NUM_PINS(NUM_PINS)) u_rirr (
        .clk            (clk),
        .rst            (rst),
        .eoi_valid      (eoi_valid),
        .eoi_vector     (eoi_vector),
        .ent_vector     (ent_vector),
        .trig_level     (ent_trig),
        .level_sent     (level_sent),
        .rirr           (remote_irr),
        .rirr_after_eoi (rirr_eff)
    );

    // an end-of-interrupt seen this cycle already unblocks its pins here
    assign eligible = pending & ~ent_mask & ~(ent_trig & rirr_eff);

    irq_pick_lowest #(.NUM_PINS(NUM_PINS)) u_pick (
        .req       (eligible),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    assign slot_free  = !msg_valid || msg_ready;
    assign load       = grant_any && slot_free;
    assign sent       = load ? grant : '0;
    assign edge_sent  = sent & ~ent_trig;
    assign level_sent = sent & ent_trig;

    always_comb begin
        if (ent_dlv[grant_idx] == DLV_EXTINT) begin
            sel_vec = extint_vector;
        end else begin
            sel_vec = ent_vector[grant_idx];
        end
        msg_d.addr = form_addr(ent_dest[grant_idx], ent_dmode[grant_idx]);
        msg_d.data = form_data(sel_vec, ent_dlv[grant_idx], ent_trig[grant_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_q     <= msg_d;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

endmodule

// File: rtl/irq_delivery_checker.sv
module irq_delivery_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [31:0]         msg_addr,
    input logic [31:0]         msg_data,
    input logic [NUM_PINS-1:0] remote_irr,
    input logic [NUM_PINS-1:0] ent_trig
);

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))) // R10
        else $error("stalled message changed");

    AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:3] == 9'd0 && msg_addr[1:0] == 2'd0)) // R8
        else $error("address outside message window");

    AST_DATA_SHAPE: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_data[31:16] == 16'd0 && msg_data[14:11] == 4'd0)) // R8
        else $error("data reserved bits set");

    AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((remote_irr & ~$past(ent_trig)) == '0)) // R12
        else $error("edge pin keeps remote irr");

    AST_ONE_RIRR_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(remote_irr & ~$past(remote_irr)) <= 1)) // R4
        else $error("more than one pin serviced in a cycle");

endmodule

bind irq_delivery_engine irq_delivery_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .remote_irr (remote_irr),
    .ent_trig   (ent_trig)
);

// File: tb/tb_irq_delivery_engine.sv
module tb_irq_delivery_engine;

    localparam int  NP       = 8;
    localparam time CLK_PER  = 10;
    localparam int  WATCHDOG = 20000;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NP-1:0]         irq_in = '0;
    logic [NP-1:0][7:0]    ent_vector = '0;
    logic [NP-1:0][2:0]    ent_dlv = '0;
    logic [NP-1:0][15:0]   ent_dest = '0;
    logic [NP-1:0]         ent_dmode = '0;
    logic [NP-1:0]         ent_trig = '0;
    logic [NP-1:0]         ent_mask = '0;
    logic [7:0]            extint_vector = '0;
    logic                  eoi_valid = 1'b0;
    logic [7:0]            eoi_vector = '0;
    logic                  msg_valid;
    logic                  msg_ready = 1'b1;
    logic [31:0]           msg_addr;
    logic [31:0]           msg_data;
    logic [NP-1:0]         remote_irr;

    int n_checks = 0;
    int n_fail   = 0;
    int got      = 0;
    int cycles   = 0;
    bit done     = 1'b0;
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];

    always #(CLK_PER/2) clk = ~clk;

    irq_delivery_engine #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ent_vector(ent_vector),
        .ent_dlv(ent_dlv), .ent_dest(ent_dest), .ent_dmode(ent_dmode),
        .ent_trig(ent_trig), .ent_mask(ent_mask), .extint_vector(extint_vector),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
        .remote_irr(remote_irr)
    );

    // record every accepted message
    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready && got < 64) begin
            log_addr[got] <= msg_addr;
            log_data[got] <= msg_data;
            got <= got + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eoi(input logic [7:0] v);
        eoi_vector = v;
        eoi_valid  = 1'b1;
        tick(1);
        eoi_valid  = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset;
        tick(2);
        check("R1 valid in reset", 32'(msg_valid), 32'd0);
        check("R1 rirr in reset", 32'(remote_irr), 32'd0);
        rst = 1'b0;
        tick(1);
        check("R1 valid after reset", 32'(msg_valid), 32'd0);
        check("R1 rirr after reset", 32'(remote_irr), 32'd0);
    endtask

    task automatic t_edge_format;
        int base;
        base = got;
        ent_vector[1] = 8'h31; ent_dest[1] = 16'h00AB; ent_dmode[1] = 1'b0;
        irq_in[1] = 1'b1;
        tick(6);
        check("R5 one message per edge", 32'(got - base), 32'd1);
        check("R8 edge address", log_addr[base], 32'hFEEAB000);
        check("R8 edge data", log_data[base], 32'h0000_0031);
        irq_in[1] = 1'b0;
        tick(2);
    endtask

    task automatic t_order;
        int base;
        base = got;
        ent_vector[3] = 8'h33;
        irq_in[3] = 1'b1; irq_in[1] = 1'b1;
        tick(6);
        check("R4 count", 32'(got - base), 32'd2);
        check("R4 lowest first", 32'(log_data[base][7:0]), 32'h31);
        check("R4 second", 32'(log_data[base+1][7:0]), 32'h33);
        irq_in[3] = 1'b0; irq_in[1] = 1'b0;
        tick(2);
    endtask

    task automatic t_masked_edge;
        int base;
        base = got;
        ent_vector[4] = 8'h34; ent_mask[4] = 1'b1;
        irq_in[4] = 1'b1;
        tick(4);
        ent_mask[4] = 1'b0;
        tick(5);
        check("R3 masked edge dropped", 32'(got - base), 32'd0);
        irq_in[4] = 1'b0;
        tick(2);
    endtask

    task automatic t_extint;
        int base;
        base = got;
        ent_vector[5] = 8'h12; ent_dlv[5] = 3'b111; ent_dest[5] = 16'h0003;
        ent_dmode[5] = 1'b1; extint_vector = 8'h77;
        irq_in[5] = 1'b1;
        tick(6);
        check("R9 count", 32'(got - base), 32'd1);
        check("R9 extint data", log_data[base], 32'h0000_0777);
        check("R8 dmode address", log_addr[base], 32'hFEE03004);
        irq_in[5] = 1'b0;
        tick(2);
    endtask

    task automatic t_level_eoi;
        int base;
        base = got;
        ent_vector[2] = 8'h40; ent_dlv[2] = 3'b001; ent_dest[2] = 16'h0010;
        ent_dmode[2] = 1'b1; ent_trig[2] = 1'b1;
        irq_in[2] = 1'b1;
        tick(6);
        check("R6 first level message", 32'(got - base), 32'd1);
        check("R8 level address", log_addr[base], 32'hFEE10004);
        check("R8 level data", log_data[base], 32'h0000_8140);
        check("R6 rirr set", 32'(remote_irr[2]), 32'd1);
        tick(6);
        check("R6 no redelivery while rirr", 32'(got - base), 32'd1);
        pulse_eoi(8'h41);
        tick(4);
        check("R7 other vector ignored count", 32'(got - base), 32'd1);
        check("R7 other vector ignored rirr", 32'(remote_irr[2]), 32'd1);
        pulse_eoi(8'h40);
        tick(5);
        check("R7 redelivered after eoi", 32'(got - base), 32'd2);
        check("R7 rirr set again", 32'(remote_irr[2]), 32'd1);
        irq_in[2] = 1'b0;
        tick(2);
        pulse_eoi(8'h40);
        tick(5);
        check("R2 no message after input low", 32'(got - base), 32'd2);
        check("R2 rirr cleared", 32'(remote_irr[2]), 32'd0);
    endtask

    task automatic t_stall_eoi;
        int base;
        base = got;
        irq_in[2] = 1'b1;
        tick(5);
        check("R6 level delivered", 32'(remote_irr[2]), 32'd1);
        msg_ready = 1'b0;
        ent_vector[0] = 8'h30;
        irq_in[0] = 1'b1;
        tick(4);
        check("R10 valid while stalled", 32'(msg_valid), 32'd1);
        check("R10 parked data", msg_data, 32'h0000_0030);
        tick(3);
        check("R10 parked data held", msg_data, 32'h0000_0030);
        pulse_eoi(8'h40);
        check("R11 rirr cleared during stall", 32'(remote_irr[2]), 32'd0);
        check("R11 parked message intact", msg_data, 32'h0000_0030);
        check("R10 nothing accepted during stall", 32'(got - base), 32'd1);
        msg_ready = 1'b1;
        tick(5);
        check("R10 count after release", 32'(got - base), 32'd3);
        check("R10 parked first", log_data[base+1], 32'h0000_0030);
        check("R11 redelivery second", 32'(log_data[base+2][7:0]), 32'h40);
        check("R11 rirr set again", 32'(remote_irr[2]), 32'd1);
        irq_in[0] = 1'b0;
        tick(2);
    endtask

    task automatic t_trig_switch;
        int base;
        base = got;
        ent_mask[2] = 1'b1;
        ent_trig[2] = 1'b0;
        tick(2);
        check("R12 edge entry clears rirr", 32'(remote_irr[2]), 32'd0);
        irq_in[2] = 1'b0;
        ent_trig[2] = 1'b1;
        tick(3);
        ent_mask[2] = 1'b0;
        tick(4);
        check("R13 masked pin not serviced", 32'(got - base), 32'd0);
    endtask

    task automatic t_masked_level;
        int base;
        base = got;
        ent_vector[6] = 8'h66; ent_trig[6] = 1'b1; ent_mask[6] = 1'b1;
        irq_in[6] = 1'b1;
        tick(6);
        check("R13 masked level held", 32'(got - base), 32'd0);
        ent_mask[6] = 1'b0;
        tick(5);
        check("R13 delivered on unmask", 32'(got - base), 32'd1);
        check("R13 vector", 32'(log_data[base][7:0]), 32'h66);
        irq_in[6] = 1'b0;
        tick(2);
        pulse_eoi(8'h66);
        tick(3);
    endtask

    initial begin
        t_reset();
        t_edge_format();
        t_order();
        t_masked_edge();
        t_extint();
        t_level_eoi();
        t_stall_eoi();
        t_trig_switch();
        t_masked_level();
        finish_run();
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

endmodule